// File: doc/BRIEF.md
# SPI Memory Access Bridge

This block is an SPI slave (mode 0) that lets an external host read and write a 32-bit-addressed internal memory. Every transaction begins, after chip select falls, with a header: an opcode byte and then a four-byte address, most significant byte first. Reads insert a fixed run of dummy bytes on the wire so the bridge can fetch memory ahead of the data phase. Writes place data straight after the header.

Two transfer sizes are supported. A single-word command moves one 4-byte word. A burst command moves consecutive 8-byte wire words, with the address advancing by 8 per word, up to a configurable byte limit. Each wire word is sent with its highest-addressed memory byte first, while memory holds bytes little-endian.

The SPI pins are oversampled in the system clock domain through two-flop synchronizers. The memory side is a synchronous 32-bit port: read data returns in the cycle after the request.

Top module: `spi_mem_bridge`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso` is 0 and no memory request is issued.
- R2: Opcode 0x02 reads one word. Header and dummy bytes (4 by default) return 0 on MISO. The following 4 bytes return memory bytes A+3, A+2, A+1, A, each most significant bit first. A is the address captured most significant byte first, and it appears on `mem_addr`.
- R3: Opcode 0x03 writes one word. The 4 data bytes after the header go to memory bytes A+3 down to A as one request with `mem_be` = 4'b1111. No write is issued before the fourth data byte has arrived.
- R4: Opcode 0x04 is a burst read. After the dummy bytes, wire word k returns memory bytes A+8k+7 down to A+8k.
- R5: Opcode 0x05 is a burst write. Each complete 8-byte wire word k writes bytes A+8k+7 down to A+8k, as two full-word requests.
- R6: If chip select rises in the middle of a data word, the partial word is dropped and never written. The next transaction decodes a fresh opcode.
- R7: Opcodes 0x00, 0x01 and every value above 0x05 cause no memory access, and MISO stays 0 until chip select rises.
- R8: Address bits [1:0] are treated as zero for every command.
- R9: A single-word command moves exactly one word. Later read bytes return 0, and later write bytes, including the trailing dummy byte, write nothing.
- R10: A burst moves at most MAX_BURST_BYTES/8 wire words. Bytes past that limit return 0 on reads and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_req | output | 1 | Memory access strobe, one cycle per word |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench targets the points where the wire order and the memory order meet:
- A bridge that reversed the wrong span (per 4 bytes inside a burst, or not at all) returns the right bytes in the wrong places.
- A prefetch that arrived late would put stale or zero bytes into the first data byte after the dummy phase.
- Committing a write before the word completes, or on the trailing dummy byte, shows up as extra write requests, which the bench counts at the port.
- A burst that ignores its limit, or misaligned address bits that leak through, corrupts memory words next to the target. The bench catches this by comparing the whole memory against its own model after every write scenario.
- Unknown opcodes are swept to show that they cause no access and keep MISO silent.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [1:0] {
    PH_HDR   = 2'd0,
    PH_DUMMY = 2'd1,
    PH_DATA  = 2'd2,
    PH_IDLE  = 2'd3
  } phase_t;

  typedef struct packed {
    logic ok;
    logic wr;
    logic burst;
  } cmd_t;

  function automatic cmd_t decode_op(input logic [7:0] op);
    cmd_t c;
    c = '0;
    unique case (op)
      8'h02: c = '{ok: 1'b1, wr: 1'b0, burst: 1'b0};
      8'h03: c = '{ok: 1'b1, wr: 1'b1, burst: 1'b0};
      8'h04: c = '{ok: 1'b1, wr: 1'b0, burst: 1'b1};
      8'h05: c = '{ok: 1'b1, wr: 1'b1, burst: 1'b1};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic mosi_s
);
  // stage bit order: {sclk, cs_n, mosi}
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] stage_q [STAGES];
  logic [2:0] last_s;
  logic       sclk_prev_q;
  logic       sclk_prev_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [2:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = {sclk, cs_n, mosi};
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= IDLE_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign last_s      = stage_q[STAGES-1];
  assign sclk_prev_d = last_s[2];
  assign cs_active   = ~last_s[1];
  assign mosi_s      = last_s[0];
  assign sclk_rise   = cs_active &  last_s[2] & ~sclk_prev_q;
  assign sclk_fall   = cs_active & ~last_s[2] &  sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_prev_d;
  end

endmodule

// File: rtl/spi_bridge_shift.sv
module spi_bridge_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       byte_valid,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [7:0] rx_q, rx_d;
  logic       miso_q, miso_d;

  always_comb begin
    bit_cnt_d  = bit_cnt_q;
    rx_d       = rx_q;
    miso_d     = miso_q;
    byte_valid = 1'b0;
    if (!cs_active) begin
      bit_cnt_d = 3'd0;
      miso_d    = 1'b0;
    end else if (sclk_rise) begin
      rx_d       = {rx_q[6:0], mosi_s};
      bit_cnt_d  = bit_cnt_q + 3'd1;
      byte_valid = (bit_cnt_q == 3'd7);
    end else if (sclk_fall) begin
      miso_d = tx_byte[3'd7 - bit_cnt_q];
    end
  end

  assign rx_byte = {rx_q[6:0], mosi_s};
  assign miso    = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= 3'd0;
      rx_q      <= 8'd0;
      miso_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      rx_q      <= rx_d;
      miso_q    <= miso_d;
    end
  end

  // R2
  byte_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

endmodule

// File: rtl/spi_bridge_memseq.sv
module spi_bridge_memseq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_we,
  input  logic                start_two,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [2*DATA_W-1:0] start_wdata,
  output logic [2*DATA_W-1:0] rd_buf,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int BE_W = DATA_W / 8;

  logic                busy_q, busy_d;
  logic                idx_q, idx_d;
  logic                two_q, two_d;
  logic                we_q, we_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [2*DATA_W-1:0] wdata_q, wdata_d;
  logic                cap_q, cap_d;
  logic                cap_idx_q, cap_idx_d;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    two_d   = two_q;
    we_d    = we_q;
    base_d  = base_q;
    wdata_d = wdata_q;
    if (start) begin
      busy_d  = 1'b1;
      idx_d   = 1'b0;
      two_d   = start_two;
      we_d    = start_we;
      base_d  = start_addr;
      wdata_d = start_wdata;
    end else if (busy_q) begin
      if (idx_q == two_q) busy_d = 1'b0;
      else                idx_d  = 1'b1;
    end
    cap_d     = busy_q & ~we_q;
    cap_idx_d = idx_q;
  end

  assign mem_req   = busy_q;
  assign mem_we    = busy_q & we_q;
  assign mem_addr  = base_q + ADDR_W'({idx_q, 2'b00});
  assign mem_wdata = idx_q ? wdata_q[2*DATA_W-1:DATA_W] : wdata_q[DATA_W-1:0];
  assign mem_be    = {BE_W{busy_q & we_q}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idx_q     <= 1'b0;
      two_q     <= 1'b0;
      we_q      <= 1'b0;
      base_q    <= '0;
      wdata_q   <= '0;
      cap_q     <= 1'b0;
      cap_idx_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      idx_q     <= idx_d;
      two_q     <= two_d;
      we_q      <= we_d;
      base_q    <= base_d;
      wdata_q   <= wdata_d;
      cap_q     <= cap_d;
      cap_idx_q <= cap_idx_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DATA_W-1:0] half_q;
    logic              half_en;
    assign half_en = cap_q & (cap_idx_q == 1'(h));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half_q <= '0;
      else if (half_en) half_q <= mem_rdata;
    end
    assign rd_buf[h*DATA_W +: DATA_W] = half_q;
  end

  // R5
  seq_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R8
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_addr[1:0] == 2'b00));

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DUMMY_BYTES = 4,
  parameter int MAX_WORDS   = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_active,
  input  logic               byte_valid,
  input  logic [7:0]         rx_byte,
  input  logic [63:0]        rd_buf,
  output logic [7:0]         tx_byte,
  output logic               seq_start,
  output logic               seq_we,
  output logic               seq_two,
  output logic [ADDR_W-1:0]  seq_addr,
  output logic [63:0]        seq_wdata
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = 4;
  localparam int WORD_W     = $clog2(MAX_WORDS + 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_t              cmd_q, cmd_d, cmd_new;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [63:0]       active_q, active_d;
  logic [63:0]       wacc_q, wacc_d;
  logic [CNT_W-1:0]  last_idx;
  logic [2:0]        sel;

  assign cmd_new  = decode_op(rx_byte);
  assign last_idx = cmd_q.burst ? CNT_W'(7) : CNT_W'(3);
  assign sel      = 3'(last_idx - cnt_q);
  assign tx_byte  = (phase_q == PH_DATA && !cmd_q.wr) ? active_q[{sel, 3'b000} +: 8] : 8'd0;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    cmd_d     = cmd_q;
    addr_d    = addr_q;
    word_d    = word_q;
    active_d  = active_q;
    wacc_d    = wacc_q;
    seq_start = 1'b0;
    seq_we    = 1'b0;
    seq_two   = 1'b0;
    seq_addr  = addr_q;
    seq_wdata = {wacc_q[55:0], rx_byte};
    if (!cs_active) begin
      phase_d = PH_HDR;
      cnt_d   = '0;
      word_d  = '0;
    end else if (byte_valid) begin
      unique case (phase_q)
        PH_HDR: begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == '0) begin
            cmd_d = cmd_new;
            if (!cmd_new.ok) phase_d = PH_IDLE;
          end else begin
            addr_d = {addr_q[ADDR_W-9:0], rx_byte};
            if (cnt_q == CNT_W'(ADDR_BYTES)) begin
              addr_d[1:0] = 2'b00;
              cnt_d       = '0;
              if (cmd_q.wr) begin
                phase_d = PH_DATA;
              end else begin
                phase_d   = PH_DUMMY;
                seq_start = 1'b1;
                seq_two   = cmd_q.burst;
                seq_addr  = addr_d;
              end
            end
          end
        end
        PH_DUMMY: begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DUMMY_BYTES - 1)) begin
            cnt_d    = '0;
            phase_d  = PH_DATA;
            active_d = rd_buf;
            if (cmd_q.burst && MAX_WORDS > 1) begin
              seq_start = 1'b1;
              seq_two   = 1'b1;
              seq_addr  = addr_q + ADDR_W'(8);
            end
          end
        end
        PH_DATA: begin
          cnt_d  = cnt_q + CNT_W'(1);
          wacc_d = {wacc_q[55:0], rx_byte};
          if (cnt_q == last_idx) begin
            cnt_d    = '0;
            word_d   = word_q + WORD_W'(1);
            addr_d   = addr_q + ADDR_W'(8);
            active_d = rd_buf;
            if (cmd_q.wr) begin
              seq_start = 1'b1;
              seq_we    = 1'b1;
              seq_two   = cmd_q.burst;
              seq_addr  = addr_q;
            end else if (cmd_q.burst && (int'(word_q) + 2 < MAX_WORDS)) begin
              seq_start = 1'b1;
              seq_two   = 1'b1;
              seq_addr  = addr_q + ADDR_W'(16);
            end
            if (!cmd_q.burst || (int'(word_q) + 1 >= MAX_WORDS)) phase_d = PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR;
      cnt_q    <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      word_q   <= '0;
      active_q <= '0;
      wacc_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      addr_q   <= addr_d;
      word_q   <= word_d;
      active_q <= active_d;
      wacc_q   <= wacc_d;
    end
  end

  // R10
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (int'(word_q) < MAX_WORDS));

  // R7
  ignored_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && cs_active) |=> !seq_start);

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
  parameter int ADDR_W          = 32,
  parameter int DUMMY_BYTES     = 4,
  parameter int MAX_BURST_BYTES = 240,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int MAX_WORDS = MAX_BURST_BYTES / 8;

  logic              sclk_rise, sclk_fall, cs_active, mosi_s;
  logic              byte_valid;
  logic [7:0]        rx_byte, tx_byte;
  logic [63:0]       rd_buf, seq_wdata;
  logic              seq_start, seq_we, seq_two;
  logic [ADDR_W-1:0] seq_addr;

  spi_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_active (cs_active),
    .mosi_s    (mosi_s)
  );

  spi_bridge_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .mosi_s     (mosi_s),
    .tx_byte    (tx_byte),
    .byte_valid (byte_valid),
    .rx_byte    (rx_byte),
    .miso       (spi_miso)
  );

  spi_bridge_ctrl #(
    .ADDR_W      (ADDR_W),
    .DUMMY_BYTES (DUMMY_BYTES),
    .MAX_WORDS   (MAX_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .byte_valid (byte_valid),
    .rx_byte    (rx_byte),
    .rd_buf     (rd_buf),
    .tx_byte    (tx_byte),
    .seq_start  (seq_start),
    .seq_we     (seq_we),
    .seq_two    (seq_two),
    .seq_addr   (seq_addr),
    .seq_wdata  (seq_wdata)
  );

  spi_bridge_memseq #(.ADDR_W(ADDR_W), .DATA_W(32)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .start_we    (seq_we),
    .start_two   (seq_two),
    .start_addr  (seq_addr),
    .start_wdata (seq_wdata),
    .rd_buf      (rd_buf),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata)
  );

  // R1
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !spi_miso);

endmodule

// File: tb/spi_mem_bridge_test.sv
module spi_mem_bridge_test;
  localparam int HALF = 6;
  localparam int LIMIT_WORDS = 4;

  logic        clk, rst_n;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] ram    [64];
  logic [31:0] shadow [64];
  int          rd_cnt, wr_cnt;
  logic [31:0] last_addr;
  int          checks, errors;

  spi_mem_bridge #(.MAX_BURST_BYTES(LIMIT_WORDS * 8)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] init_word(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b + 8'h70, b ^ 8'h5A, 8'(i * 3) + 8'h11, b + 8'h80};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ram[i] <= init_word(i);
      rd_cnt <= 0;
      wr_cnt <= 0;
      last_addr <= '0;
      mem_rdata <= '0;
    end else if (mem_req) begin
      last_addr <= mem_addr;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= ram[mem_addr[7:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input logic [31:0] a);
    return shadow[a[7:2]][8*a[1:0] +: 8];
  endfunction

  task automatic sbyte(input logic [31:0] a, input logic [7:0] v);
    shadow[a[7:2]][8*a[1:0] +: 8] = v;
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 64; i++) if (ram[i] !== shadow[i]) bad++;
    chk_eq(req, bad, 0);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      rx[i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [31:0] a, output logic [7:0] acc);
    logic [7:0] rx;
    xfer(op, rx);
    acc = rx;
    for (int i = 3; i >= 0; i--) begin
      xfer(a[8*i +: 8], rx);
      acc |= rx;
    end
  endtask

  task automatic skip_dummy(output logic [7:0] acc);
    logic [7:0] rx;
    acc = 0;
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, rx);
      acc |= rx;
    end
  endtask

  task automatic burst_rd(input logic [31:0] a, input int n);
    logic [7:0] rx, acc;
    cs_low;
    send_hdr(8'h04, a, acc);
    chk_eq("R4 header miso", acc, 0);
    skip_dummy(acc);
    chk_eq("R4 dummy miso", acc, 0);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        xfer(8'h00, rx);
        if (k < LIMIT_WORDS) chk_eq("R4 burst read byte", rx, rbyte(a + 8*k + 7 - j));
        else                 chk_eq("R10 read past limit", rx, 0);
      end
    cs_high;
  endtask

  task automatic burst_wr(input string req, input logic [31:0] a, input int n, input int tail);
    logic [7:0] rx, acc, v;
    int wb, done;
    wb = wr_cnt;
    cs_low;
    send_hdr(8'h05, a, acc);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        v = 8'(a + 32'(16*k + 3*j + 1));
        xfer(v, rx);
        if (k < LIMIT_WORDS) sbyte(a + 32'(8*k + 7 - j), v);
      end
    for (int t = 0; t < tail; t++) xfer(8'hEE, rx);
    cs_high;
    done = (n < LIMIT_WORDS) ? n : LIMIT_WORDS;
    chk_eq({req, " write count"}, wr_cnt - wb, 2 * done);
    compare({req, " memory image"});
  endtask

  initial begin
    logic [7:0] rx, acc;
    logic [31:0] a;
    int rb, wb;
    logic [7:0] bad_ops [8];
    checks = 0;
    errors = 0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) shadow[i] = init_word(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 miso after reset", spi_miso, 0);
    chk_eq("R1 no access after reset", rd_cnt + wr_cnt, 0);

    // R2 / R9: single-word read sweep
    for (int w = 0; w < 16; w++) begin
      a = {8'h60 ^ 8'(w), 8'h03, 8'h00, 8'(w * 4)};
      rb = rd_cnt;
      cs_low;
      send_hdr(8'h02, a, acc);
      chk_eq("R2 header miso", acc, 0);
      skip_dummy(acc);
      chk_eq("R2 dummy miso", acc, 0);
      for (int i = 0; i < 4; i++) begin
        xfer(8'h00, rx);
        chk_eq("R2 read byte", rx, rbyte(a + 32'(3 - i)));
      end
      xfer(8'h00, rx);
      chk_eq("R9 byte after single read", rx, 0);
      cs_high;
      chk_eq("R2 address on port", last_addr, a);
      chk_eq("R9 one read request", rd_cnt - rb, 1);
    end

    // R3 / R9: single-word write sweep
    for (int w = 0; w < 8; w++) begin
      a = 32'h5FFC_9800 + 32'((16 + w) * 4);
      wb = wr_cnt;
      cs_low;
      send_hdr(8'h03, a, acc);
      for (int i = 0; i < 3; i++) begin
        xfer(8'(8'hC0 + 4*w + i), rx);
        sbyte(a + 32'(3 - i), 8'(8'hC0 + 4*w + i));
      end
      repeat (8) @(negedge clk);
      chk_eq("R3 no early commit", wr_cnt - wb, 0);
      xfer(8'(8'hC0 + 4*w + 3), rx);
      sbyte(a, 8'(8'hC0 + 4*w + 3));
      xfer(8'hEE, rx);
      cs_high;
      chk_eq("R9 single write request", wr_cnt - wb, 1);
      compare("R3 memory image");
    end

    // R8: misaligned low address bits
    cs_low;
    send_hdr(8'h03, 32'h0000_0053, acc);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); xfer(8'h44, rx);
    cs_high;
    shadow[20] = 32'h1122_3344;
    compare("R8 write alignment");
    cs_low;
    send_hdr(8'h02, 32'h0000_005A, acc);
    skip_dummy(acc);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, rx);
      chk_eq("R8 read alignment", rx, rbyte(32'h58 + 32'(3 - i)));
    end
    cs_high;

    // R4 / R10: burst reads
    burst_rd(32'h0000_0020, 2);
    burst_rd(32'h0000_0044, 5);

    // R5 / R10 / R6: burst writes
    burst_wr("R5", 32'h0000_0080, 3, 1);
    burst_wr("R10", 32'h0000_00C0, 5, 1);
    burst_wr("R6", 32'h0000_00A0, 1, 5);

    // R6: partial single write then fresh transaction
    wb = wr_cnt;
    cs_low;
    send_hdr(8'h03, 32'h0000_00B8, acc);
    xfer(8'h99, rx); xfer(8'h98, rx);
    cs_high;
    chk_eq("R6 partial word dropped", wr_cnt - wb, 0);
    compare("R6 memory image");
    cs_low;
    send_hdr(8'h02, 32'h0000_00B8, acc);
    skip_dummy(acc);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, rx);
      chk_eq("R6 fresh read", rx, rbyte(32'hB8 + 32'(3 - i)));
    end
    cs_high;

    // R7: ignored opcodes
    bad_ops = '{8'h00, 8'h01, 8'h06, 8'h07, 8'h10, 8'h42, 8'h83, 8'hFF};
    for (int o = 0; o < 8; o++) begin
      rb = rd_cnt + wr_cnt;
      cs_low;
      send_hdr(bad_ops[o], 32'h0000_0010, acc);
      for (int i = 0; i < 8; i++) begin
        xfer(8'hA5, rx);
        acc |= rx;
      end
      cs_high;
      chk_eq("R7 miso silent", acc, 0);
      chk_eq("R7 no access", rd_cnt + wr_cnt - rb, 0);
    end
    compare("R7 memory image");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule